// File: doc/BRIEF.md
# Cascadable Synchronous Presettable Binary Counter

A synchronous up-counter built from 4-bit cells that can be chained into a wider counter. It is meant for programmable dividers and multistage counters. All state changes happen on the rising clock edge. Four modes are ranked in a fixed order: clear to zero, parallel preset from a data bus, count up by one, and hold. Clear and preset are active-low. Counting needs two enables. The parallel enable only gates counting. The trickle enable gates counting and also qualifies the terminal-count flag.

The top module chains `STAGES` cells of `STAGE_W` bits each, and every cell shares the one clock. The `LOOKAHEAD` parameter picks how the cells are connected. In the ripple form, each cell's terminal count feeds the trickle enable of the next cell. In the lookahead form, the first cell's terminal count, ANDed with the parallel enable, feeds the parallel enable of every later cell. The trickle enables still ripple through the intermediate cells. Either form behaves, at the ports, as one counter of `STAGE_W*STAGES` bits. The register has no asynchronous reset: a synchronous clear puts it in a known state.

Top module: `cnt_cascade`

## Requirements
- R1: When `clr_n` is 0 at a rising edge, `count` becomes 0 after that edge, whatever the values of `load_n`, `en_par`, `en_trk` and `data`.
- R2: When `clr_n` is 1 and `load_n` is 0 at a rising edge, `count` takes the value of `data` after that edge, whatever the values of the two enables.
- R3: When `clr_n`, `load_n`, `en_par` and `en_trk` are all 1 at a rising edge, `count` becomes the previous count plus one, modulo 2^(STAGE_W*STAGES). The all-ones value wraps to 0.
- R4: When `clr_n` and `load_n` are 1 and either enable is 0 at a rising edge, `count` keeps its value.
- R5: `tc` is 1 exactly when `count` is all ones and `en_trk` is 1. It follows these inputs combinationally and does not depend on `en_par`.
- R6: With `LOOKAHEAD`=0 (ripple form), a multi-cell chain meets R1 to R5 as one wide counter, including every carry across a cell boundary.
- R7: With `LOOKAHEAD`=1 (lookahead form), a multi-cell chain meets R1 to R5 as one wide counter, including every carry across a cell boundary.
- R8: `count` changes only at a rising clock edge. Changing any input between edges leaves `count` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel preset, active low |
| en_par | input | 1 | Parallel count enable |
| en_trk | input | 1 | Trickle count enable; also qualifies `tc` |
| data | input | STAGE_W*STAGES | Preset value |
| count | output | STAGE_W*STAGES | Current count |
| tc | output | 1 | Terminal count: count all ones and `en_trk` high |

## Verification
The bench first targets mode precedence. A clear applied together with a preset must still give zero; a design with the priority reversed would load `data` instead. It then drives the wide chains through the carries from 0x0EF, 0x0FF and 0xFFF. A chain with a wrong enable connection would carry too early, carry too late, or let an upper cell count while the lowest cell holds. The bench also checks `tc` with only one of the two enables low: a flag gated by `en_par` would drop when it should stay high. Finally, it changes inputs in the middle of a cycle and confirms the count does not move before the next edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_COUNT = 2'd2,
        MODE_HOLD  = 2'd3
    } mode_t;

    typedef struct packed {
        logic clr_n;
        logic load_n;
        logic en_par;
        logic en_trk;
    } stage_ctl_t;

    // Fixed precedence: clear, then load, then count, then hold.
    function automatic mode_t pick_mode(input stage_ctl_t ctl);
        if (!ctl.clr_n)                  return MODE_CLEAR;
        else if (!ctl.load_n)            return MODE_LOAD;
        else if (ctl.en_par && ctl.en_trk) return MODE_COUNT;
        else                             return MODE_HOLD;
    endfunction

endpackage

// File: rtl/cnt_mode_sel.sv
module cnt_mode_sel
    import cnt_pkg::*;
(
    input  stage_ctl_t ctl,
    output mode_t      mode
);
    always_comb begin
        mode = pick_mode(ctl);
    end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
    import cnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  stage_ctl_t   ctl,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         tc
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] ONE      = W'(1);

    mode_t        mode;
    logic [W-1:0] q_next;

    cnt_mode_sel u_mode (
        .ctl  (ctl),
        .mode (mode)
    );

    always_comb begin
        unique case (mode)
            MODE_CLEAR: q_next = '0;
            MODE_LOAD:  q_next = din;
            MODE_COUNT: q_next = q + ONE;
            default:    q_next = q;
        endcase
    end

    // No asynchronous reset: the synchronous clear initializes the cell.
    always_ff @(posedge clk) begin
        q <= q_next;
    end

    assign tc = (q == ALL_ONES) && ctl.en_trk;
endmodule

// File: rtl/cnt_cascade.sv
module cnt_cascade
    import cnt_pkg::*;
#(
    parameter int STAGE_W   = 4,
    parameter int STAGES    = 1,
    parameter bit LOOKAHEAD = 1'b0
) (
    input  logic                        clk,
    input  logic                        clr_n,
    input  logic                        load_n,
    input  logic                        en_par,
    input  logic                        en_trk,
    input  logic [STAGE_W*STAGES-1:0]   data,
    output logic [STAGE_W*STAGES-1:0]   count,
    output logic                        tc
);
    localparam int TOT_W = STAGE_W * STAGES;

    logic [STAGES-1:0] st_tc;
    logic [STAGES-1:0] st_enp;
    logic [STAGES-1:0] st_ent;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        stage_ctl_t ctl;

        if (k == 0) begin : g_first
            assign st_enp[k] = en_par;
            assign st_ent[k] = en_trk;
        end else if (!LOOKAHEAD) begin : g_ripple
            assign st_enp[k] = en_par;
            assign st_ent[k] = st_tc[k-1];
        end else begin : g_look
            assign st_enp[k] = en_par & st_tc[0];
            if (k == 1) begin : g_second
                assign st_ent[k] = en_trk;
            end else begin : g_later
                assign st_ent[k] = st_tc[k-1];
            end
        end

        assign ctl.clr_n  = clr_n;
        assign ctl.load_n = load_n;
        assign ctl.en_par = st_enp[k];
        assign ctl.en_trk = st_ent[k];

        cnt_stage #(.W(STAGE_W)) u_stage (
            .clk (clk),
            .ctl (ctl),
            .din (data[k*STAGE_W +: STAGE_W]),
            .q   (count[k*STAGE_W +: STAGE_W]),
            .tc  (st_tc[k])
        );
    end

    if (LOOKAHEAD && STAGES > 1) begin : g_tc_look
        // Upper cells see the trickle chain from cell 1; cell 0 is added here.
        assign tc = st_tc[STAGES-1] & st_tc[0];
    end else begin : g_tc_ripple
        assign tc = st_tc[STAGES-1];
    end
endmodule

// File: rtl/cnt_cascade_chk.sv
module cnt_cascade_chk #(
    parameter int TOT_W = 4
) (
    input logic             clk,
    input logic             clr_n,
    input logic             load_n,
    input logic             en_par,
    input logic             en_trk,
    input logic [TOT_W-1:0] data,
    input logic [TOT_W-1:0] count,
    input logic             tc
);
    logic seen_clr = 1'b0;

    always_ff @(posedge clk) begin
        if (!clr_n) seen_clr <= 1'b1;
    end

    // R1
    clr_zero_chk: assert property (@(posedge clk) disable iff (!seen_clr)
        !clr_n |=> count == '0);

    // R2
    load_val_chk: assert property (@(posedge clk) disable iff (!seen_clr)
        (clr_n && !load_n) |=> count == $past(data));

    // R3
    count_inc_chk: assert property (@(posedge clk) disable iff (!seen_clr)
        (clr_n && load_n && en_par && en_trk) |=> count == $past(count) + TOT_W'(1));

    // R4
    hold_val_chk: assert property (@(posedge clk) disable iff (!seen_clr)
        (clr_n && load_n && !(en_par && en_trk)) |=> $stable(count));

    // R5
    tc_needs_trk_chk: assert property (@(posedge clk) disable iff (!seen_clr)
        tc |-> (en_trk && count == {TOT_W{1'b1}}));

    // R5
    tc_full_chk: assert property (@(posedge clk) disable iff (!seen_clr)
        (en_trk && count == {TOT_W{1'b1}}) |-> tc);
endmodule

bind cnt_cascade cnt_cascade_chk #(.TOT_W(STAGE_W*STAGES)) u_chk (
    .clk    (clk),
    .clr_n  (clr_n),
    .load_n (load_n),
    .en_par (en_par),
    .en_trk (en_trk),
    .data   (data),
    .count  (count),
    .tc     (tc)
);

// File: tb/cnt_cascade_bench.sv
`timescale 1ns/1ps
module cnt_cascade_bench;
    localparam int N  = 3;
    localparam int CW = 4 * N;
    localparam logic [11:0] M1 = 12'h00F;
    localparam logic [11:0] MC = 12'hFFF;

    logic          clk = 1'b0;
    logic          clr_n = 1'b1, load_n = 1'b1, en_par = 1'b0, en_trk = 1'b0;
    logic [CW-1:0] data = '0;
    logic [3:0]    cnt_s;
    logic [CW-1:0] cnt_r, cnt_l;
    logic          tc_s, tc_r, tc_l;

    int checks = 0, fails = 0;
    bit inited = 1'b0, done = 1'b0;
    logic [11:0] ref_s = '0, ref_c = '0;

    always #5 clk = ~clk;

    cnt_cascade u_cnt_cascade (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
        .en_trk(en_trk), .data(data[3:0]), .count(cnt_s), .tc(tc_s));

    cnt_cascade #(.STAGE_W(4), .STAGES(N), .LOOKAHEAD(1'b0)) u_ripple (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
        .en_trk(en_trk), .data(data), .count(cnt_r), .tc(tc_r));

    cnt_cascade #(.STAGE_W(4), .STAGES(N), .LOOKAHEAD(1'b1)) u_look (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
        .en_trk(en_trk), .data(data), .count(cnt_l), .tc(tc_l));

    function automatic logic [11:0] model_next(input logic [11:0] cur, input logic c,
        input logic l, input logic ep, input logic et, input logic [11:0] d,
        input logic [11:0] mask);
        if (!c) return '0;
        if (!l) return d & mask;
        if (ep && et) return (cur + 12'd1) & mask;
        return cur;
    endfunction

    function automatic logic model_tc(input logic [11:0] cur, input logic et,
        input logic [11:0] mask);
        return et && ((cur & mask) == mask);
    endfunction

    function automatic string mode_tag(input logic c, input logic l, input logic ep,
        input logic et);
        if (!c) return "R1";
        if (!l) return "R2";
        if (ep && et) return "R3";
        return "R4";
    endfunction

    task automatic check(input bit ok, input string tag, input logic [11:0] act,
        input logic [11:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic l, input logic ep, input logic et,
        input logic [11:0] d);
        logic [11:0] nx_s, nx_c;
        string tag;
        @(negedge clk);
        clr_n = c; load_n = l; en_par = ep; en_trk = et; data = d;
        #1;
        if (inited) begin
            // R8: new inputs must not move the count before the edge
            check(cnt_s == ref_s[3:0], "R8 single", 12'(cnt_s), ref_s);
            check(cnt_r == ref_c, "R8 ripple", cnt_r, ref_c);
            check(cnt_l == ref_c, "R8 lookahead", cnt_l, ref_c);
            check(tc_s == model_tc(ref_s, et, M1), "R5 single tc", 12'(tc_s),
                  12'(model_tc(ref_s, et, M1)));
            check(tc_r == model_tc(ref_c, et, MC), "R5 R6 ripple tc", 12'(tc_r),
                  12'(model_tc(ref_c, et, MC)));
            check(tc_l == model_tc(ref_c, et, MC), "R5 R7 lookahead tc", 12'(tc_l),
                  12'(model_tc(ref_c, et, MC)));
        end
        nx_s = model_next(ref_s, c, l, ep, et, d, M1);
        nx_c = model_next(ref_c, c, l, ep, et, d, MC);
        tag  = mode_tag(c, l, ep, et);
        @(posedge clk);
        #1;
        if (inited || !c) begin
            check(cnt_s == nx_s[3:0], {tag, " single"}, 12'(cnt_s), nx_s);
            check(cnt_r == nx_c, {tag, " R6 ripple"}, cnt_r, nx_c);
            check(cnt_l == nx_c, {tag, " R7 lookahead"}, cnt_l, nx_c);
            inited = 1'b1;
        end
        ref_s = nx_s;
        ref_c = nx_c;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h5EED);
        // R1: clear beats load and both enables
        step(1'b0, 1'b0, 1'b1, 1'b1, 12'hABC);
        check(tc_s == 1'b0 && tc_r == 1'b0 && tc_l == 1'b0, "R1 reset tc",
              {9'd0, tc_s, tc_r, tc_l}, 12'd0);
        // R2: load ignores enables
        step(1'b1, 1'b0, 1'b0, 1'b0, 12'hFFD);
        // R3: count through full wrap of wide and single counter
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 12'h000);
        // R5: tc stays high with en_par low; R4 hold
        step(1'b1, 1'b0, 1'b1, 1'b1, 12'hFFF);
        step(1'b1, 1'b1, 1'b0, 1'b1, 12'h123);
        step(1'b1, 1'b1, 1'b1, 1'b0, 12'h123);
        step(1'b1, 1'b1, 1'b0, 1'b0, 12'h123);
        // R6 R7: carries across cell boundaries
        step(1'b1, 1'b0, 1'b0, 1'b1, 12'h0EF);
        step(1'b1, 1'b1, 1'b1, 1'b1, 12'h000);
        step(1'b1, 1'b0, 1'b1, 1'b0, 12'h0FF);
        step(1'b1, 1'b1, 1'b1, 1'b1, 12'h000);
        // Lowest cell held at all ones: upper cells must hold too
        step(1'b1, 1'b0, 1'b1, 1'b1, 12'h0FF);
        step(1'b1, 1'b1, 1'b0, 1'b1, 12'h000);
        step(1'b1, 1'b1, 1'b1, 1'b0, 12'h000);
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[3:0] != 4'd0, r[6:4] != 3'd0, r[8:7] != 2'd0, r[10:9] != 2'd0,
                 r[31:20]);
        end
        // Long count run for repeated wraps
        step(1'b1, 1'b0, 1'b0, 1'b0, 12'hF00);
        for (int i = 0; i < 300; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 12'h000);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule